// File: doc/BRIEF.md
# Floating-point control and status register

This block is the 32-bit control/status register that sits beside a floating-point datapath. Software writes it to choose a rounding mode and to load a five-bit exception field. Software reads it to see the control fields together with the exception flags that the arithmetic units have gathered. The arithmetic units report exceptions as single-cycle pulses on a five-bit input, and the register keeps each flag set until the next write.

The datapath gets a registered two-bit rounding selection. It is decoded from the three-bit mode field, and only when a write actually changes that field. Mode codes with no supported meaning are rejected. A rejected code leaves the datapath rounding unchanged and raises a one-cycle error strobe.

Top module: `fpcsr_top`

## Requirements
- R1: After reset, `rd_data` reads zero, `rnd_mode` is 0 (nearest-even) and `mode_err` is low.
- R2: A write stores `wr_data` ANDed with the writable mask. The mask covers the mode field at bits [18:16] and the exception-load field at bits [12:8]. Every other stored bit reads back as zero.
- R3: `rd_data` is the stored value ORed with the live exception flags at bits [4:0]. The bit order is invalid at bit 0, divide-by-zero at 1, overflow at 2, underflow at 3 and inexact at 4.
- R4: With no write in a cycle, each `flag_in` bit is ORed into its flag at the clock edge, and a flag that is set stays set.
- R5: A write replaces all five flags with `wr_data[12:8]`, using the same bit order as R3. A `flag_in` pulse in the same cycle is discarded.
- R6: Mode codes map to `rnd_mode` as follows: 0 gives 0 (nearest-even), 1 gives 1 (toward zero), 2 gives 2 (toward +infinity) and 3 gives 3 (toward -infinity). The new value appears in the cycle after the write.
- R7: A write that changes the mode field to 4, 5, 6 or 7 pulses `mode_err` high for exactly the cycle after the write and leaves `rnd_mode` unchanged. The rejected code is still stored and read back.
- R8: A write whose mode field equals the stored mode field neither re-decodes the mode nor raises `mode_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 32 | Value to write |
| flag_in | input | 5 | Exception pulses from the arithmetic units |
| rd_data | output | 32 | Read value: stored fields ORed with the live flags |
| rnd_mode | output | 2 | Decoded rounding mode for the datapath |
| mode_err | output | 1 | One-cycle strobe when an unsupported mode is written |

## Verification
The assertions are disabled only by the external reset. The reset release passes through a two-stage synchronizer, so they assume that `wr_en` and `flag_in` stay idle for the first cycles after `rst_n` rises. The bench holds both inputs at zero for several cycles after release before it drives anything. After that it drives writes and flag pulses at the falling edge, always as whole-cycle values.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
  localparam int unsigned CSR_W    = 32;
  localparam int unsigned FLAG_N   = 5;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned MODE_LSB = 16;
  localparam int unsigned TE_LSB   = 8;
  localparam int unsigned FLAG_LSB = 0;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_POS     = 2'd2,
    RND_NEG     = 2'd3
  } rnd_e;

  function automatic logic [CSR_W-1:0] field_mask(input int unsigned lsb, input int unsigned w);
    logic [CSR_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpcsr_rst_sync.sv
module fpcsr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fpcsr_flag_acc.sv
module fpcsr_flag_acc #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic [N-1:0] set_in,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic d;
    logic q;

    always_comb begin
      if (load) d = load_val[g];
      else      d = q | set_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= d;
    end

    assign flags[g] = q;
  end
endmodule

// File: rtl/fpcsr_round_dec.sv
module fpcsr_round_dec
  import fpcsr_pkg::*;
#(
  parameter int unsigned MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [MW-1:0] new_mode,
  input  logic [MW-1:0] old_mode,
  output rnd_e          rnd_mode,
  output logic          err
);
  logic changed;
  logic legal;
  logic upd_en;
  rnd_e rnd_d;
  logic err_d;
  rnd_e rnd_q;
  logic err_q;

  always_comb begin
    changed = wr_en && (new_mode != old_mode);
    legal   = (new_mode < MW'(4));
    upd_en  = changed && legal;
    err_d   = changed && !legal;
    case (new_mode[1:0])
      2'd0:    rnd_d = RND_NEAREST;
      2'd1:    rnd_d = RND_ZERO;
      2'd2:    rnd_d = RND_POS;
      default: rnd_d = RND_NEG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rnd_q <= RND_NEAREST;
    else if (upd_en) rnd_q <= rnd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign rnd_mode = rnd_q;
  assign err      = err_q;
endmodule

// File: rtl/fpcsr_top.sv
module fpcsr_top
  import fpcsr_pkg::*;
#(
  parameter int unsigned W      = CSR_W,
  parameter int unsigned NF     = FLAG_N,
  parameter int unsigned MW     = MODE_W,
  parameter int unsigned M_LSB  = MODE_LSB,
  parameter int unsigned T_LSB  = TE_LSB,
  parameter int unsigned F_LSB  = FLAG_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [NF-1:0] flag_in,
  output logic [W-1:0]  rd_data,
  output logic [1:0]    rnd_mode,
  output logic          mode_err
);
  localparam logic [W-1:0] WR_MASK = field_mask(M_LSB, MW) | field_mask(T_LSB, NF);

  logic          rst_n_s;
  logic [W-1:0]  store_d;
  logic [W-1:0]  store_q;
  logic [NF-1:0] flags;
  logic [W-1:0]  flags_pos;
  rnd_e          rnd_int;

  fpcsr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    store_d = wr_data & WR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   store_q <= '0;
    else if (wr_en) store_q <= store_d;
  end

  fpcsr_flag_acc #(.N(NF)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (wr_en),
    .load_val (wr_data[T_LSB +: NF]),
    .set_in   (flag_in),
    .flags    (flags)
  );

  fpcsr_round_dec #(.MW(MW)) u_rnd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (wr_en),
    .new_mode (wr_data[M_LSB +: MW]),
    .old_mode (store_q[M_LSB +: MW]),
    .rnd_mode (rnd_int),
    .err      (mode_err)
  );

  always_comb begin
    flags_pos = '0;
    flags_pos[F_LSB +: NF] = flags;
    rd_data   = store_q | flags_pos;
    rnd_mode  = rnd_int;
  end
endmodule

// File: rtl/fpcsr_chk.sv
module fpcsr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [4:0]  flag_in,
  input logic [31:0] rd_data,
  input logic [1:0]  rnd_mode,
  input logic        mode_err
);
  localparam logic [31:0] LEGAL_BITS = 32'h0007_1F1F;

  AST_RD_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LEGAL_BITS) == 32'h0); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data[4:0] & $past(rd_data[4:0])) == $past(rd_data[4:0]))); // R4

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((rd_data[4:0] & $past(flag_in)) == $past(flag_in))); // R4

  AST_WR_LOADS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[4:0] == $past(wr_data[12:8]))); // R5

  AST_ERR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[18] && (wr_data[18:16] != rd_data[18:16])) |=> (mode_err && $stable(rnd_mode))); // R7

  AST_NO_ERR_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !mode_err); // R7

  AST_SAME_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[18:16] == rd_data[18:16])) |=> (!mode_err && $stable(rnd_mode))); // R8
endmodule

bind fpcsr_top fpcsr_chk u_chk (.*);

// File: tb/sim_fpcsr_top.sv
module sim_fpcsr_top;
  localparam int PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [4:0]  flag_in;
  logic [31:0] rd_data;
  logic [1:0]  rnd_mode;
  logic        mode_err;

  fpcsr_top u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_in  (flag_in),
    .rd_data  (rd_data),
    .rnd_mode (rnd_mode),
    .mode_err (mode_err)
  );

  typedef struct {
    logic [31:0] rd;
    logic [1:0]  rnd;
    logic        err;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   finished = 0;

  logic [31:0] m_store;
  logic [4:0]  m_flags;
  logic [1:0]  m_rnd;
  logic        m_err;

  initial begin
    clk = 1'b0;
    forever #(PERIOD/2) clk = ~clk;
  end

  task automatic check(input string tag, input exp_t e);
    n_tests++;
    if (rd_data !== e.rd || rnd_mode !== e.rnd || mode_err !== e.err) begin
      n_fail++;
      $display("FAIL %s: rd=%h rnd=%0d err=%0b expected rd=%h rnd=%0d err=%0b",
               tag, rd_data, rnd_mode, mode_err, e.rd, e.rnd, e.err);
    end
  endtask

  task automatic drive(input string tag, input logic w, input logic [31:0] d, input logic [4:0] f);
    exp_t e;
    logic [2:0] nm;
    @(negedge clk);
    wr_en = w; wr_data = d; flag_in = f;
    nm = d[18:16];
    m_err = 1'b0;
    if (w) begin
      if (nm != m_store[18:16]) begin
        if (nm < 3'd4) m_rnd = nm[1:0];
        else           m_err = 1'b1;
      end
      m_store = d & 32'h0007_1F00;
      m_flags = d[12:8];
    end else begin
      m_flags = m_flags | f;
    end
    @(posedge clk);
    #1;
    e.rd = m_store | {27'd0, m_flags};
    e.rnd = m_rnd; e.err = m_err; e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.tag, e);
      end
    end
  end

  function automatic logic [31:0] wv(input logic [2:0] mode, input logic [4:0] te, input logic [31:0] junk);
    return junk | {13'd0, mode, 3'd0, te, 8'd0};
  endfunction

  initial begin : main
    exp_t r;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; flag_in = '0;
    m_store = '0; m_flags = '0; m_rnd = 2'd0; m_err = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    r.rd = '0; r.rnd = 2'd0; r.err = 1'b0; r.tag = "R1 reset";
    check("R1 reset values", r);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    drive("R4 invalid pulse",         1'b0, 32'h0, 5'b00001);
    drive("R4 R3 more flags sticky",  1'b0, 32'h0, 5'b10100);
    drive("R4 R3 idle keeps flags",   1'b0, 32'h0, 5'b00000);
    drive("R2 R5 R6 write mode1 w/ pulse", 1'b1, wv(3'd1, 5'b00010, 32'hF0F0_E0FF), 5'b11111);
    drive("R7 mode4 rejected",        1'b1, wv(3'd4, 5'b00010, 32'h0), 5'b00000);
    drive("R8 mode4 rewrite quiet",   1'b1, wv(3'd4, 5'b01000, 32'h0), 5'b00000);
    drive("R6 mode2",                 1'b1, wv(3'd2, 5'b00000, 32'h0), 5'b00000);
    drive("R7 mode5 rejected",        1'b1, wv(3'd5, 5'b11111, 32'h0), 5'b00000);
    drive("R4 pulse after write",     1'b0, 32'h0, 5'b00000);
    drive("R6 mode3",                 1'b1, wv(3'd3, 5'b00100, 32'h8000_0000), 5'b00001);
    drive("R8 mode3 rewrite",         1'b1, wv(3'd3, 5'b00000, 32'h0), 5'b00000);
    drive("R7 mode6 rejected",        1'b1, wv(3'd6, 5'b00000, 32'h0), 5'b00000);
    drive("R6 mode0 nearest",         1'b1, wv(3'd0, 5'b10000, 32'h0), 5'b00000);
    drive("R4 R3 overflow+underflow", 1'b0, 32'h0, 5'b01100);
    drive("R7 mode7 rejected",        1'b1, wv(3'd7, 5'b00000, 32'h0), 5'b00010);
    drive("R6 mode1 after reject",    1'b1, wv(3'd1, 5'b00000, 32'h0), 5'b00000);
    drive("R2 idle readback",         1'b0, 32'h0, 5'b00000);
    @(negedge clk);
    wr_en = 1'b0; flag_in = '0;
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule